// File: doc/BRIEF.md
# Floating-Point Compare and Condition Field Writer

This block compares two IEEE 754 double-precision operands and stores a four-flag verdict (less, greater, equal, unordered) into one selectable 4-bit field of a packed 32-bit condition register. The other seven fields keep their values. A second operation copies one 4-bit field of a floating-point status word into a chosen condition field. This lets status flags reach the condition register without a compare.

The condition register can always be read on a read-back port. A constant output gives the default quiet NaN. A result path uses this value when an invalid operation did not involve a NaN operand. The reset is asynchronous and active low, and its release is synchronised to the clock by two flops inside the block.

Top module: `fcmp_crupd`

## Requirements
- R1: The condition register has eight 4-bit fields. Field k occupies read-back bits [31-4k : 28-4k], so field 0 is the most significant nibble. The status word given to the move operation uses the same layout.
- R2: While reset is asserted, every condition field reads 4'b0000. Asserting reset clears the register without waiting for a clock edge.
- R3: For an ordered compare with A < B, the written nibble is 4'b1000. The most significant nibble bit is the less flag.
- R4: For an ordered compare with A > B, the written nibble is 4'b0100. For A = B it is 4'b0010. Exactly one flag is set in any compare result.
- R5: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN, the nibble is 4'b0001 (unordered flag only). Infinities are ordered values.
- R6: A move copies status field `mov_src` into condition field `mov_dst`.
- R7: A write takes effect at the clock edge where `cmp_vld` or `mov_vld` is high, and the new value is visible on `cr_q` after that edge. Only the selected nibble changes. With both strobes low, `cr_q` holds its value.
- R8: Positive zero and negative zero compare equal (4'b0010).
- R9: Ordering uses sign and magnitude. A negative operand is below any positive one. When both operands are negative, the larger magnitude is the lesser value.
- R10: When `cmp_vld` and `mov_vld` are high in the same cycle, only the compare result is written, and the move is discarded.
- R11: `dflt_qnan` is always 64'h7FF8_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cmp_vld | input | 1 | Compare strobe: write the compare result this edge |
| cmp_a | input | 64 | Operand A, double precision |
| cmp_b | input | 64 | Operand B, double precision |
| cmp_dst | input | 3 | Destination condition field for the compare |
| mov_vld | input | 1 | Move strobe: copy a status field this edge |
| mov_src | input | 3 | Source field index within `fpst_in` |
| mov_dst | input | 3 | Destination condition field for the move |
| fpst_in | input | 32 | Floating-point status word, eight 4-bit fields |
| cr_q | output | 32 | Read-back of the condition register |
| dflt_qnan | output | 64 | Default quiet NaN constant |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and eight 4-bit fields. These values make the whole double-precision corner set reachable: signed zeros, subnormals, infinities, and quiet and signalling NaNs of both signs. Every field index can be targeted as both source and destination. With eight fields, a single compare write can be shown to leave seven neighbours intact, and the compare-over-move priority can be exercised both with distinct destinations and with a shared destination.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Width of one condition / status field
  localparam int FLD_W = 4;

  // Compare verdict, most significant bit first
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic un;
  } cmp_res_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter  int EXP_W = 11,
  parameter  int FRAC_W = 52,
  localparam int DW    = 1 + EXP_W + FRAC_W,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [DW-1:0]    opnd_i,
  output logic             sign_o,
  output logic             nan_o,
  output logic             zero_o,
  output logic [MAG_W-1:0] mag_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign_o = opnd_i[DW-1];
  assign exp_f  = opnd_i[DW-2 -: EXP_W];
  assign frac_f = opnd_i[FRAC_W-1:0];
  assign mag_o  = opnd_i[MAG_W-1:0];

  always_comb begin
    nan_o  = (&exp_f) && (|frac_f);
    zero_o = ~|mag_o;
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a_i,
  input  logic             nan_a_i,
  input  logic             zero_a_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic             sign_b_i,
  input  logic             nan_b_i,
  input  logic             zero_b_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output cmp_res_t         res_o
);

  logic mag_eq;
  logic mag_a_big;

  assign mag_eq    = (mag_a_i == mag_b_i);
  assign mag_a_big = (mag_a_i >  mag_b_i);

  always_comb begin
    res_o = '0;
    if (nan_a_i || nan_b_i) begin
      res_o.un = 1'b1;
    end else if (zero_a_i && zero_b_i) begin
      res_o.eq = 1'b1;
    end else if (sign_a_i != sign_b_i) begin
      res_o.lt = sign_a_i;
      res_o.gt = sign_b_i;
    end else if (mag_eq) begin
      res_o.eq = 1'b1;
    end else begin
      // same sign: negative operands invert magnitude order
      res_o.gt = mag_a_big ^ sign_a_i;
      res_o.lt = ~(mag_a_big ^ sign_a_i);
    end
  end

endmodule

// File: rtl/cr_field_bank.sv
module cr_field_bank #(
  parameter  int NFLD  = 8,
  parameter  int FLD_W = 4,
  localparam int SEL_W = (NFLD > 1) ? $clog2(NFLD) : 1,
  localparam int CR_W  = NFLD * FLD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp_i,
  input  logic [SEL_W-1:0] cmp_dst_i,
  input  logic [FLD_W-1:0] cmp_nib_i,
  input  logic             wr_mov_i,
  input  logic [SEL_W-1:0] mov_dst_i,
  input  logic [FLD_W-1:0] mov_nib_i,
  output logic [CR_W-1:0]  cr_q
);

  logic             wr_en;
  logic [SEL_W-1:0] wr_sel;
  logic [FLD_W-1:0] wr_nib;
  logic [CR_W-1:0]  cr_d;

  // next-state: compare has priority over move
  always_comb begin
    wr_en  = 1'b0;
    wr_sel = '0;
    wr_nib = '0;
    if (wr_cmp_i) begin
      wr_en  = 1'b1;
      wr_sel = cmp_dst_i;
      wr_nib = cmp_nib_i;
    end else if (wr_mov_i) begin
      wr_en  = 1'b1;
      wr_sel = mov_dst_i;
      wr_nib = mov_nib_i;
    end
    cr_d = cr_q;
    for (int k = 0; k < NFLD; k++) begin
      if (wr_sel == SEL_W'(k)) begin
        cr_d[CR_W-1-k*FLD_W -: FLD_W] = wr_nib;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= '0;
    end else if (wr_en) begin
      cr_q <= cr_d;
    end
  end

  function automatic logic [FLD_W-1:0] fld_of(input logic [CR_W-1:0] v,
                                                input logic [SEL_W-1:0] idx);
    return v[CR_W-1-int'(idx)*FLD_W -: FLD_W];
  endfunction

  function automatic logic [CR_W-1:0] keep_mask(input logic [SEL_W-1:0] idx);
    logic [CR_W-1:0] m;
    m = '1;
    m[CR_W-1-int'(idx)*FLD_W -: FLD_W] = '0;
    return m;
  endfunction

  // R2: register reads zero when reset releases
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cr_q == '0);

  // R4: a compare verdict carries exactly one flag
  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp_i |-> $countones(cmp_nib_i) == 1);

  // R7: no strobe, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_cmp_i || wr_mov_i) |=> $stable(cr_q));

  // R7: compare leaves neighbour fields untouched
  p_neighbours_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp_i |=> (cr_q & keep_mask($past(cmp_dst_i))) ==
                 ($past(cr_q) & keep_mask($past(cmp_dst_i))));

  // R10: compare result lands even with a concurrent move
  p_cmp_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp_i |=> fld_of(cr_q, $past(cmp_dst_i)) == $past(cmp_nib_i));

  // R6: a lone move copies its nibble
  p_move_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mov_i && !wr_cmp_i) |=> fld_of(cr_q, $past(mov_dst_i)) == $past(mov_nib_i));

endmodule

// File: rtl/fcmp_crupd.sv
module fcmp_crupd
  import fcmp_pkg::*;
#(
  parameter  int EXP_W  = 11,
  parameter  int FRAC_W = 52,
  parameter  int NFLD   = 8,
  localparam int DW     = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int SEL_W  = (NFLD > 1) ? $clog2(NFLD) : 1,
  localparam int CR_W   = NFLD * FLD_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             cmp_vld,
  input  logic [DW-1:0]    cmp_a,
  input  logic [DW-1:0]    cmp_b,
  input  logic [SEL_W-1:0] cmp_dst,
  input  logic             mov_vld,
  input  logic [SEL_W-1:0] mov_src,
  input  logic [SEL_W-1:0] mov_dst,
  input  logic [CR_W-1:0]  fpst_in,
  output logic [CR_W-1:0]  cr_q,
  output logic [DW-1:0]    dflt_qnan
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  // operand classification, one instance per operand
  logic [DW-1:0]    opnd [2];
  logic [1:0]       sgn;
  logic [1:0]       nan;
  logic [1:0]       zro;
  logic [MAG_W-1:0] mag [2];

  assign opnd[0] = cmp_a;
  assign opnd[1] = cmp_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
    ) u_cls (
      .opnd_i (opnd[g]),
      .sign_o (sgn[g]),
      .nan_o  (nan[g]),
      .zero_o (zro[g]),
      .mag_o  (mag[g])
    );
  end

  cmp_res_t         res;
  logic [FLD_W-1:0] cmp_nib;
  logic [FLD_W-1:0] mov_nib;

  fcmp_order #(
    .MAG_W (MAG_W)
  ) u_order (
    .sign_a_i (sgn[0]),
    .nan_a_i  (nan[0]),
    .zero_a_i (zro[0]),
    .mag_a_i  (mag[0]),
    .sign_b_i (sgn[1]),
    .nan_b_i  (nan[1]),
    .zero_b_i (zro[1]),
    .mag_b_i  (mag[1]),
    .res_o    (res)
  );

  assign cmp_nib = res;
  assign mov_nib = fpst_in[CR_W-1-int'(mov_src)*FLD_W -: FLD_W];

  cr_field_bank #(
    .NFLD  (NFLD),
    .FLD_W (FLD_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_cmp_i  (cmp_vld),
    .cmp_dst_i (cmp_dst),
    .cmp_nib_i (cmp_nib),
    .wr_mov_i  (mov_vld),
    .mov_dst_i (mov_dst),
    .mov_nib_i (mov_nib),
    .cr_q      (cr_q)
  );

  // quiet NaN: sign 0, exponent all ones, top fraction bit only
  assign dflt_qnan = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // R5: any NaN operand gives the unordered verdict alone
  p_nan_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (nan[0] || nan[1]) |-> cmp_nib == 4'b0001);

  // R8: signed zeros compare equal
  p_zero_equal_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (zro[0] && zro[1]) |-> cmp_nib == 4'b0010);

  // R9: two negatives with larger |A| means A is less
  p_neg_invert_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sgn[0] && sgn[1] && !nan[0] && !nan[1] && mag[0] > mag[1]) |-> res.lt);

  // R11: quiet NaN pattern fields
  p_qnan_shape_r11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!dflt_qnan[DW-1] && dflt_qnan[FRAC_W-1]) |-> &dflt_qnan[DW-2 -: EXP_W]);

endmodule

// File: tb/fcmp_crupd_tb.sv
`timescale 1ns/1ps
module fcmp_crupd_tb;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        cmp_vld;
  logic [63:0] cmp_a;
  logic [63:0] cmp_b;
  logic [2:0]  cmp_dst;
  logic        mov_vld;
  logic [2:0]  mov_src;
  logic [2:0]  mov_dst;
  logic [31:0] fpst_in;
  logic [31:0] cr_q;
  logic [63:0] dflt_qnan;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] model;

  always #4 clk = ~clk;

  fcmp_crupd u_dut (
    .clk       (clk),
    .arst_n    (arst_n),
    .cmp_vld   (cmp_vld),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_dst   (cmp_dst),
    .mov_vld   (mov_vld),
    .mov_src   (mov_src),
    .mov_dst   (mov_dst),
    .fpst_in   (fpst_in),
    .cr_q      (cr_q),
    .dflt_qnan (dflt_qnan)
  );

  // {A, B, dst, expected nibble}
  localparam int NV = 16;
  localparam logic [134:0] VECS [NV] = '{
    {64'h3FF0000000000000, 64'h4000000000000000, 3'd0, 4'b1000}, // R3 1<2
    {64'h4000000000000000, 64'h3FF0000000000000, 3'd1, 4'b0100}, // R4 2>1
    {64'h3FF0000000000000, 64'h3FF0000000000000, 3'd2, 4'b0010}, // R4 eq
    {64'h0000000000000000, 64'h8000000000000000, 3'd3, 4'b0010}, // R8
    {64'hBFF0000000000000, 64'hC000000000000000, 3'd4, 4'b0100}, // R9 -1>-2
    {64'hC000000000000000, 64'hBFF0000000000000, 3'd5, 4'b1000}, // R9 -2<-1
    {64'hBFF0000000000000, 64'h3FF0000000000000, 3'd6, 4'b1000}, // R9 sign
    {64'h7FF8000000000000, 64'h3FF0000000000000, 3'd7, 4'b0001}, // R5 qNaN
    {64'h3FF0000000000000, 64'h7FF0000000000001, 3'd0, 4'b0001}, // R5 sNaN
    {64'h7FF0000000000000, 64'h3FF0000000000000, 3'd1, 4'b0100}, // R5 inf
    {64'hFFF0000000000000, 64'h7FF0000000000000, 3'd2, 4'b1000}, // R5 -inf
    {64'h7FF0000000000000, 64'h7FF0000000000000, 3'd3, 4'b0010}, // R5 inf=inf
    {64'h0000000000000001, 64'h0000000000000000, 3'd4, 4'b0100}, // R4 subnormal
    {64'hFFF8000000000000, 64'hFFF8000000000000, 3'd5, 4'b0001}, // R5 -NaN
    {64'h3FF0000000000000, 64'h3FF0000000000001, 3'd6, 4'b1000}, // R3 ulp
    {64'h8000000000000000, 64'h8000000000000001, 3'd7, 4'b0100}  // R9 -0>-tiny
  };

  function automatic logic [31:0] put_fld(input logic [31:0] v, input int idx,
                                          input logic [3:0] nib);
    logic [31:0] r;
    r = v;
    r[31-idx*4 -: 4] = nib;
    return r;
  endfunction

  function automatic logic [3:0] get_fld(input logic [31:0] v, input int idx);
    return v[31-idx*4 -: 4];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic [2:0] d);
    @(negedge clk);
    cmp_a = a; cmp_b = b; cmp_dst = d; cmp_vld = 1'b1;
    @(negedge clk);
    cmp_vld = 1'b0;
  endtask

  task automatic do_mov(input logic [2:0] s, input logic [2:0] d);
    @(negedge clk);
    mov_src = s; mov_dst = d; mov_vld = 1'b1;
    @(negedge clk);
    mov_vld = 1'b0;
  endtask

  initial begin
    arst_n = 1'b0; cmp_vld = 1'b0; mov_vld = 1'b0;
    cmp_a = '0; cmp_b = '0; cmp_dst = '0; mov_src = '0; mov_dst = '0;
    fpst_in = 32'h1234_5678;
    model = '0;
    repeat (3) @(negedge clk);
    check("R2 reset value", {32'h0, cr_q}, 64'h0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 after release", {32'h0, cr_q}, 64'h0);
    check("R11 default qnan", dflt_qnan, 64'h7FF8_0000_0000_0000);

    // table walk: R1 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      do_cmp(VECS[i][134:71], VECS[i][70:7], VECS[i][6:4]);
      model = put_fld(model, int'(VECS[i][6:4]), VECS[i][3:0]);
      check($sformatf("R1/R7 vector %0d", i), {32'h0, cr_q}, {32'h0, model});
    end

    // R1: field 0 is the top nibble
    do_cmp(64'h3FF0000000000000, 64'h4000000000000000, 3'd0);
    check("R1 field0 msb nibble", {60'h0, cr_q[31:28]}, 64'h8);
    model = put_fld(model, 0, 4'b1000);

    // R6: moves, status field 2 -> cr field 5, field 7 -> field 0
    do_mov(3'd2, 3'd5);
    model = put_fld(model, 5, 4'h3);
    check("R6 move 2->5", {32'h0, cr_q}, {32'h0, model});
    do_mov(3'd7, 3'd0);
    model = put_fld(model, 0, 4'h8);
    check("R6 move 7->0", {32'h0, cr_q}, {32'h0, model});

    // R10: compare and move together, distinct destinations
    @(negedge clk);
    cmp_a = 64'h4000000000000000; cmp_b = 64'h3FF0000000000000; cmp_dst = 3'd3;
    mov_src = 3'd1; mov_dst = 3'd4; cmp_vld = 1'b1; mov_vld = 1'b1;
    @(negedge clk);
    cmp_vld = 1'b0; mov_vld = 1'b0;
    model = put_fld(model, 3, 4'b0100);
    check("R10 move dropped", {32'h0, cr_q}, {32'h0, model});

    // R10: same destination
    @(negedge clk);
    cmp_a = 64'h3FF0000000000000; cmp_b = 64'h3FF0000000000000; cmp_dst = 3'd6;
    mov_src = 3'd0; mov_dst = 3'd6; cmp_vld = 1'b1; mov_vld = 1'b1;
    @(negedge clk);
    cmp_vld = 1'b0; mov_vld = 1'b0;
    model = put_fld(model, 6, 4'b0010);
    check("R10 same field", {28'h0, get_fld(cr_q, 6)}, 32'h2);

    // R7: idle with changing inputs, no change
    @(negedge clk);
    cmp_a = 64'hFFF8000000000000; cmp_dst = 3'd1; mov_src = 3'd5; mov_dst = 3'd2;
    fpst_in = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    check("R7 idle hold", {32'h0, cr_q}, {32'h0, model});

    // R2: asynchronous clear mid-run
    #2 arst_n = 1'b0;
    #1 check("R2 async clear", {32'h0, cr_q}, 64'h0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 held zero", {32'h0, cr_q}, 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule